// File: doc/BRIEF.md
# Double-Precision to Signed 32-bit Integer Converter

This block takes a 64-bit IEEE 754 double-precision operand and a 2-bit rounding-mode code, and turns them into a signed 32-bit integer. Along with the integer it returns two exception flags: invalid-operation and inexact. Both flags describe only the conversion they travel with. Nothing is accumulated across conversions.

The operand enters on a valid/ready stream and the result leaves on another. The result is registered, so it appears one cycle after the input is accepted. Back-pressure follows these rules:

- The input is taken on any clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in that same cycle.
- Once `out_valid` rises, the output data and flags stay stable until `out_ready` takes them.

Operand handling by class:

- Subnormal operands are treated as zero.
- NaN operands return a fixed indefinite value.
- Infinities and operands beyond the integer range saturate by sign.
- For all other operands, overflow is judged after rounding. A negative result of exactly -2^31 is therefore accepted as legal.

Top module: `dti_conv`

## Requirements
- R1: A transfer happens when `in_valid` and `in_ready` are high at a clock edge, and its result shows `out_valid` high from the following cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_int` and both flags hold their values. After reset `out_valid` is 0.
- R2: An operand with exponent field 0x7FF and a nonzero fraction (NaN) returns 0x7FFFFFFF with invalid=1 and inexact=0.
- R3: An operand with exponent field 0x7FF and a zero fraction (infinity) returns 0x7FFFFFFF when positive and 0x80000000 when negative, with invalid=1 and inexact=0.
- R4: An operand with exponent field 0 (signed zero or subnormal) returns 0 with both flags clear, in every rounding mode.
- R5: A finite operand whose unbiased exponent is above 31 returns the sign-selected saturation value of R3, with invalid=1 and inexact=0.
- R6: Rounding mode 0 (nearest) rounds to the nearest integer and breaks exact ties toward the even integer.
- R7: Rounding mode 1 (toward zero) discards the fraction.
- R8: Rounding mode 2 (toward plus infinity) rounds up a positive inexact magnitude and leaves a negative one truncated. Rounding mode 3 (toward minus infinity) does the opposite.
- R9: If the rounded magnitude is 2^31 or more, the result is the saturation value with invalid=1 and inexact=0. The one exception is a negative operand whose rounded magnitude is exactly 2^31: it returns 0x80000000 with no invalid flag.
- R10: When the result does not overflow, inexact=1 exactly when the operand had a nonzero fraction. Invalid and inexact are never both set.
- R11: A normal operand with unbiased exponent below -1 (magnitude under 0.5) truncates to magnitude 0 and is always inexact. Such an operand rounds to 0 in modes 0 and 1, and to +1 or -1 in the matching directed mode.
- R12: A negative operand that does not overflow returns the two's-complement negation of the rounded magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand is presented |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_op | input | 64 | Double-precision operand |
| in_rm | input | 2 | Rounding mode: 0 nearest, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_int | output | 32 | Signed integer result |
| out_invalid | output | 1 | Invalid-operation flag for this result |
| out_inexact | output | 1 | Inexact flag for this result |

## Verification
Directed operands of the form n + 0.5 are run through all four modes. These tie cases separate ties-to-even from ties-away, and separate the directed modes by sign. Values just above and below the exact tie, and tiny magnitudes, show whether round and sticky are kept apart. Operands near ±2^31, with fractions on both sides of one half, check the post-rounding overflow test and its single negative exception. NaNs, infinities, signed zero and subnormals cover the fixed substitutes. Random operands with exponents around the integer range, fed under random output stalls, check the alignment shift at every position and the hold-while-stalled rule.

// File: rtl/dti_pkg.sv
package dti_pkg;
  localparam int DP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = 1023;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    CL_ZERO = 2'd0,
    CL_FIN  = 2'd1,
    CL_INF  = 2'd2,
    CL_NAN  = 2'd3
  } opclass_e;
endpackage

// File: rtl/dti_unpack.sv
module dti_unpack
  import dti_pkg::*;
#(
  parameter int OUT_W = 32,
  localparam int SH_W = $clog2(OUT_W + 1)
) (
  input  logic [DP_W-1:0]  op,
  output logic             sign,
  output opclass_e         cls,
  output logic             too_big,
  output logic             tiny,
  output logic [SH_W-1:0]  shamt,
  output logic [SIG_W-1:0] sig
);
  localparam logic [EXP_W-1:0] EXP_MAX  = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] EXP_TOP  = EXP_W'(BIAS + OUT_W - 1);

  logic [EXP_W-1:0]  expf;
  logic [FRAC_W-1:0] frac;
  logic [EXP_W-1:0]  ediff;

  assign sign  = op[DP_W-1];
  assign expf  = op[DP_W-2 -: EXP_W];
  assign frac  = op[FRAC_W-1:0];
  assign sig   = {1'b1, frac};
  assign ediff = expf - EXP_HALF;
  assign shamt = ediff[SH_W-1:0];

  always_comb begin
    if (expf == '0)           cls = CL_ZERO;
    else if (expf != EXP_MAX) cls = CL_FIN;
    else if (frac == '0)      cls = CL_INF;
    else                      cls = CL_NAN;
  end

  assign too_big = (expf > EXP_TOP);
  assign tiny    = (expf < EXP_HALF);
endmodule

// File: rtl/dti_align.sv
module dti_align
  import dti_pkg::*;
#(
  parameter int OUT_W = 32,
  localparam int SH_W = $clog2(OUT_W + 1),
  localparam int WIDE = SIG_W + OUT_W
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [SH_W-1:0]  shamt,
  input  logic             tiny,
  output logic [OUT_W-1:0] int_part,
  output logic             rnd,
  output logic             stk
);
  logic [WIDE-1:0] wide;

  assign wide = {{OUT_W{1'b0}}, sig} << shamt;

  always_comb begin
    if (tiny) begin
      int_part = '0;
      rnd      = 1'b0;
      stk      = 1'b1;
    end else begin
      int_part = wide[WIDE-1 -: OUT_W];
      rnd      = wide[FRAC_W];
      stk      = |wide[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/dti_round.sv
module dti_round
  import dti_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic [OUT_W-1:0] int_part,
  input  logic             rnd,
  input  logic             stk,
  input  logic             sign,
  input  rmode_e           rm,
  output logic [OUT_W:0]   mag,
  output logic             lost,
  output logic             ovf
);
  logic inc;

  assign lost = rnd | stk;

  always_comb begin
    unique case (rm)
      RM_NEAR: inc = rnd & (stk | int_part[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = lost & ~sign;
      RM_DOWN: inc = lost & sign;
      default: inc = 1'b0;
    endcase
  end

  assign mag = {1'b0, int_part} + (OUT_W+1)'(inc);
  assign ovf = mag[OUT_W] |
               (mag[OUT_W-1] & ~(sign & (mag[OUT_W-2:0] == '0)));
endmodule

// File: rtl/dti_conv.sv
module dti_conv
  import dti_pkg::*;
#(
  parameter int OUT_W = 32,
  localparam int SH_W = $clog2(OUT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DP_W-1:0]  in_op,
  input  logic [1:0]       in_rm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_int,
  output logic             out_invalid,
  output logic             out_inexact
);
  localparam logic [OUT_W-1:0] POS_SAT = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_SAT = {1'b1, {(OUT_W-1){1'b0}}};

  logic             sign, too_big, tiny, rnd, stk, lost, ovf;
  opclass_e         cls;
  logic [SH_W-1:0]  shamt;
  logic [SIG_W-1:0] sig;
  logic [OUT_W-1:0] int_part;
  logic [OUT_W:0]   mag;
  logic [OUT_W-1:0] sat, nx_int;
  logic             nx_inv, nx_inx, take;

  dti_unpack #(.OUT_W(OUT_W)) u_unpack (
    .op(in_op), .sign(sign), .cls(cls), .too_big(too_big),
    .tiny(tiny), .shamt(shamt), .sig(sig)
  );

  dti_align #(.OUT_W(OUT_W)) u_align (
    .sig(sig), .shamt(shamt), .tiny(tiny),
    .int_part(int_part), .rnd(rnd), .stk(stk)
  );

  dti_round #(.OUT_W(OUT_W)) u_round (
    .int_part(int_part), .rnd(rnd), .stk(stk), .sign(sign),
    .rm(rmode_e'(in_rm)), .mag(mag), .lost(lost), .ovf(ovf)
  );

  assign sat = sign ? NEG_SAT : POS_SAT;

  always_comb begin
    nx_int = '0;
    nx_inv = 1'b0;
    nx_inx = 1'b0;
    unique case (cls)
      CL_NAN:  begin nx_int = POS_SAT; nx_inv = 1'b1; end
      CL_INF:  begin nx_int = sat;     nx_inv = 1'b1; end
      CL_ZERO: nx_int = '0;
      CL_FIN: begin
        if (too_big || ovf) begin
          nx_int = sat;
          nx_inv = 1'b1;
        end else begin
          nx_int = sign ? (~mag[OUT_W-1:0] + 1'b1) : mag[OUT_W-1:0];
          nx_inx = lost;
        end
      end
      default: nx_int = '0;
    endcase
  end

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_int     <= nx_int;
        out_invalid <= nx_inv;
        out_inexact <= nx_inx;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R1
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_int) &&
      $stable(out_invalid) && $stable(out_inexact))); // R1
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact)); // R10
  AST_INVALID_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_int == POS_SAT || out_int == NEG_SAT)); // R5
  AST_NAN_INDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == CL_NAN) |=> (out_int == POS_SAT && out_invalid)); // R2
  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == CL_ZERO) |=> (out_int == '0 && !out_invalid && !out_inexact)); // R4
endmodule

// File: tb/sim_dti_conv.sv
module sim_dti_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_op = '0;
  logic [1:0]  in_rm = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_int;
  logic        out_invalid, out_inexact;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dti_conv u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rm(in_rm), .out_valid(out_valid), .out_ready(out_ready),
    .out_int(out_int), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  logic [63:0] st_op[$];
  logic [1:0]  st_rm[$];
  string       st_tag[$];
  logic [33:0] exp_q[$];
  string       tag_q[$];

  task automatic add(input logic [63:0] op, input logic [1:0] rm, input string tag);
    st_op.push_back(op); st_rm.push_back(rm); st_tag.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // Reference: {int[31:0], invalid, inexact}
  function automatic logic [33:0] ref_conv(input logic [63:0] op, input logic [1:0] rm);
    logic neg;
    int e;
    longint unsigned m, q, r, half, sh, mag;
    bit below, tie, above, inx;
    logic [31:0] sat, res;
    neg = op[63];
    sat = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
    if (op[62:52] == 11'h7FF) begin
      if (op[51:0] != 0) return {32'h7FFF_FFFF, 2'b10};
      return {sat, 2'b10};
    end
    if (op[62:52] == 0) return {32'd0, 2'b00};
    e = int'(op[62:52]) - 1023;
    if (e > 31) return {sat, 2'b10};
    m = {11'd0, 1'b1, op[51:0]};
    if (e < -1) begin
      q = 0; below = 1; tie = 0; above = 0;
    end else begin
      sh = 52 - e;
      q = m >> sh;
      r = m - (q << sh);
      half = 64'd1 << (sh - 1);
      below = (r != 0) && (r < half);
      tie = (r == half);
      above = (r > half);
    end
    inx = below | tie | above;
    mag = q;
    case (rm)
      2'd0: if (above || (tie && q[0])) mag = q + 1;
      2'd1: ;
      2'd2: if (inx && !neg) mag = q + 1;
      2'd3: if (inx && neg) mag = q + 1;
    endcase
    if (mag > 64'h7FFF_FFFF && !(neg && mag == 64'h8000_0000)) return {sat, 2'b10};
    res = mag[31:0];
    if (neg) res = -res;
    return {res, 1'b0, inx};
  endfunction

  function automatic logic [63:0] rb(input real v);
    return $realtobits(v);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Directed cases
    add(rb(2.5), 0, "R6"); add(rb(3.5), 0, "R6"); add(rb(-2.5), 0, "R6 R12");
    add(rb(0.5), 0, "R6"); add(rb(1.5), 0, "R6"); add(rb(2.5000001), 0, "R6");
    add(rb(2.4999999), 0, "R6");
    add(rb(2.9), 1, "R7"); add(rb(-2.9), 1, "R7 R12");
    add(rb(2.1), 2, "R8"); add(rb(-2.1), 2, "R8"); add(rb(2.1), 3, "R8");
    add(rb(-2.1), 3, "R8 R12"); add(rb(7.0), 2, "R10");
    add(rb(1.0e-300), 2, "R11"); add(rb(-1.0e-300), 3, "R11");
    add(rb(0.2), 0, "R11"); add(rb(-0.2), 1, "R11");
    add(64'h0000_0000_0000_0001, 2, "R4"); add(64'h8000_0000_0000_0000, 3, "R4");
    add(64'h0000_0000_0000_0000, 0, "R4");
    add(64'h7FF8_0000_0000_0000, 0, "R2"); add(64'hFFF0_0000_0000_0001, 2, "R2");
    add(64'h7FF0_0000_0000_0000, 1, "R3"); add(64'hFFF0_0000_0000_0000, 0, "R3");
    add(rb(1.0e20), 0, "R5"); add(rb(-4294967296.0), 1, "R5");
    add(rb(2147483648.0), 1, "R9"); add(rb(-2147483648.0), 1, "R9");
    add(rb(-2147483648.4), 0, "R9"); add(rb(-2147483648.6), 0, "R9");
    add(rb(2147483647.5), 0, "R9"); add(rb(2147483647.4), 1, "R9");
    add(rb(2147483647.1), 2, "R9"); add(rb(-2147483648.1), 3, "R9");
    for (int i = 0; i < 600; i++) begin
      logic [63:0] op;
      op[63] = $urandom_range(0, 1);
      op[62:52] = 11'(1016 + $urandom_range(0, 42));
      op[51:0] = {20'($urandom), $urandom};
      if (i % 7 == 0) op[20:0] = '0;
      add(op, 2'($urandom_range(0, 3)), "R6/R7/R8/R12");
    end

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", $sformatf("reset out_valid actual=%0b expected=0", out_valid));
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 3) != 0);
      if (st_op.size() > 0 && $urandom_range(0, 4) != 0) begin
        in_valid = 1'b1; in_op = st_op[0]; in_rm = st_rm[0];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      check(in_ready == (!out_valid || out_ready), "R1",
            $sformatf("in_ready actual=%0b expected=%0b", in_ready, !out_valid || out_ready));
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R1", "out_valid actual=1 expected=0");
        end else begin
          logic [33:0] ev;
          string t;
          ev = exp_q[0]; t = tag_q[0];
          check({out_int, out_invalid, out_inexact} == ev, t,
                $sformatf("int/inv/inx actual=%h/%0b/%0b expected=%h/%0b/%0b",
                          out_int, out_invalid, out_inexact, ev[33:2], ev[1], ev[0]));
          if (out_ready) begin
            void'(exp_q.pop_front()); void'(tag_q.pop_front());
          end
        end
      end else begin
        check(exp_q.size() == 0, "R1", $sformatf("out_valid actual=0 expected=%0b", exp_q.size() != 0));
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_conv(st_op[0], st_rm[0]));
        tag_q.push_back(st_tag[0]);
        void'(st_op.pop_front()); void'(st_rm.pop_front()); void'(st_tag.pop_front());
      end
      if (st_op.size() == 0 && exp_q.size() == 0 && !out_valid) break;
    end
    check(st_op.size() == 0 && exp_q.size() == 0, "R1", "stream drained actual=no expected=yes");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule